// File: doc/BRIEF.md
# Microprogram Next-Address Unit

This block works out which word of a microcode control store is read next. Each cycle it takes the current microinstruction's 9-bit successor field, three jump-control bits, the ALU sign and zero flags and the 8-bit opcode byte just fetched. It combines them into the next microprogram counter value, which it holds in a register and presents to the control store.

Conditional branches never use an adder. When a condition is selected and its flag is set, the unit forces bit 8 of the address high. The two possible targets are therefore always exactly 256 words apart. Opcode dispatch is a bitwise OR of the opcode byte into the low eight bits of the successor field. The block captures the flags at the end of every datapath cycle. The microinstruction that follows uses those captured values.

Top module: `useq_next_addr`

## Requirements
- R1: While rst_ni is low, upc_o is 0x000 and both captured flags are 0. Assertion of reset clears upc_o without waiting for a clock edge.
- R2: With use_byte_i, sel_neg_i and sel_zero_i all 0, upc_o after the next rising edge equals succ_i from before that edge.
- R3: After a rising edge, bit 8 of upc_o is (sel_neg_i AND captured N) OR (sel_zero_i AND captured Z) OR succ_i[8].
- R4: With use_byte_i at 0, upc_o[7:0] after the edge equals succ_i[7:0], whatever the flags. A conditional branch therefore reaches only succ_i with bit 8 cleared or with bit 8 set. For example, succ_i = 0x092 with sel_zero_i set goes to 0x192 when Z was 1 and to 0x092 when Z was 0.
- R5: With use_byte_i at 1, upc_o[7:0] after the edge is succ_i[7:0] bitwise ORed with opcode_i.
- R6: The captured N and Z used at an edge are the values of alu_n_i and alu_z_i sampled at the previous rising edge. They are not the values present at the current edge.
- R7: With use_byte_i at 1 and succ_i[8] at 1, upc_o[8] after the edge is 1.
- R8: upc_o changes only at a rising clock edge or on reset. Input changes between edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| succ_i | input | 9 | Successor address field of the current microinstruction |
| use_byte_i | input | 1 | Dispatch: OR opcode byte into low address bits |
| sel_neg_i | input | 1 | Branch on captured N into bit 8 |
| sel_zero_i | input | 1 | Branch on captured Z into bit 8 |
| alu_n_i | input | 1 | ALU negative flag of the current cycle |
| alu_z_i | input | 1 | ALU zero flag of the current cycle |
| opcode_i | input | 8 | Fetched opcode byte |
| upc_o | output | 9 | Microprogram counter, control store address |

## Verification
Properties are checked on every cycle. These cover pass-through of the successor field when no jump bit is set and the low byte staying put on branches. They also cover the opcode bits showing up in the low byte on dispatch and bit 8 never being lost. The one-cycle delay of the flags can only be shown by bench sequences. In those sequences the flag changes in one cycle and is then selected in the next. The bench scenarios also cover the exact 0x092/0x192 branch pair, reset in the middle of a run, and address stability between edges.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W + 1;

  typedef struct packed {
    logic use_byte;
    logic sel_neg;
    logic sel_zero;
  } jump_t;

  typedef struct packed {
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/useq_flag_reg.sv
module useq_flag_reg
  import useq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t flags_i,
  output flags_t flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= flags_i;
  end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
  import useq_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned AW = BW + 1
) (
  input  logic [AW-1:0] succ_i,
  input  jump_t         jump_i,
  input  flags_t        flags_i,
  input  logic [BW-1:0] opcode_i,
  output logic [AW-1:0] next_o
);
  logic hi_bit;

  // bit BW: condition ORed into the page bit
  assign hi_bit = (jump_i.sel_neg & flags_i.n) | (jump_i.sel_zero & flags_i.z) | succ_i[BW];

  for (genvar b = 0; b < BW; b++) begin : g_low
    assign next_o[b] = succ_i[b] | (jump_i.use_byte & opcode_i[b]);
  end
  assign next_o[BW] = hi_bit;
endmodule

// File: rtl/useq_upc_reg.sv
module useq_upc_reg #(
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] next_i,
  output logic [AW-1:0] upc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_o <= '0;
    else         upc_o <= next_i;
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] succ_i,
  input  logic              use_byte_i,
  input  logic              sel_neg_i,
  input  logic              sel_zero_i,
  input  logic              alu_n_i,
  input  logic              alu_z_i,
  input  logic [BYTE_W-1:0] opcode_i,
  output logic [ADDR_W-1:0] upc_o
);
  jump_t             jump;
  flags_t            flags_d, flags_q;
  logic [ADDR_W-1:0] next_addr;

  assign jump    = '{use_byte: use_byte_i, sel_neg: sel_neg_i, sel_zero: sel_zero_i};
  assign flags_d = '{n: alu_n_i, z: alu_z_i};

  useq_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(flags_d),
    .flags_o(flags_q)
  );

  useq_addr_mux #(.BW(BYTE_W)) u_mux (
    .succ_i  (succ_i),
    .jump_i  (jump),
    .flags_i (flags_q),
    .opcode_i(opcode_i),
    .next_o  (next_addr)
  );

  useq_upc_reg #(.AW(ADDR_W)) u_upc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .next_i(next_addr),
    .upc_o (upc_o)
  );

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (upc_o == '0));

  p_plain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!use_byte_i && !sel_neg_i && !sel_zero_i) |=> (upc_o == $past(succ_i)));

  p_low_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_byte_i |=> (upc_o[BYTE_W-1:0] == $past(succ_i[BYTE_W-1:0])));

  p_byte_in_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_byte_i |=> ((upc_o[BYTE_W-1:0] & $past(opcode_i)) == $past(opcode_i)));

  p_page_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    succ_i[BYTE_W] |=> upc_o[BYTE_W]);

  p_no_branch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!succ_i[BYTE_W] && !sel_neg_i && !sel_zero_i) |=> !upc_o[BYTE_W]);
endmodule

// File: tb/tb_useq_next_addr.sv
module tb_useq_next_addr;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [8:0] succ;
  logic       ub, sn, sz, an, az;
  logic [7:0] opc;
  logic [8:0] upc;

  int n_checks = 0;
  int n_fail   = 0;
  bit fn_m, fz_m;  // model of captured flags
  logic [8:0] exp_q [$];

  always #4 clk = ~clk;

  useq_next_addr dut (
    .clk_i(clk), .rst_ni(rst_ni), .succ_i(succ), .use_byte_i(ub),
    .sel_neg_i(sn), .sel_zero_i(sz), .alu_n_i(an), .alu_z_i(az),
    .opcode_i(opc), .upc_o(upc)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: upc=%03h expected %03h", tag, act, exp);
    end
  endtask

  // drive one microinstruction, clock it, compare against model at negedge
  task automatic step(input logic [8:0] na, input bit j, input bit n_sel, input bit z_sel,
                      input bit nf, input bit zf, input logic [7:0] ob, input string tag);
    logic [8:0] e;
    succ = na; ub = j; sn = n_sel; sz = z_sel; an = nf; az = zf; opc = ob;
    e[8]   = (n_sel & fn_m) | (z_sel & fz_m) | na[8];
    e[7:0] = na[7:0] | (j ? ob : 8'h00);
    exp_q.push_back(e);
    @(posedge clk);
    fn_m = nf; fz_m = zf;
    @(negedge clk);
    chk(tag, upc, exp_q.pop_front());
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: upc=%03h expected completion", upc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [8:0] hold;
    rst_ni = 1'b0; succ = '0; ub = 0; sn = 0; sz = 0; an = 1; az = 1; opc = '0;
    fn_m = 0; fz_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset value", upc, 9'h000);
    rst_ni = 1'b1;

    step(9'h0A5, 0, 0, 0, 0, 0, 8'hFF, "R2 plain pass");
    step(9'h1C3, 0, 0, 0, 1, 1, 8'h3C, "R2 plain high page");
    // Z=1 captured, now branch on Z from 0x092
    step(9'h092, 0, 0, 1, 0, 0, 8'h00, "R4 branch taken 0x192");
    chk("R4 taken target", upc, 9'h192);
    step(9'h092, 0, 0, 1, 0, 0, 8'h00, "R4 branch not taken 0x092");
    chk("R4 fallthrough target", upc, 9'h092);
    // R6: flag set this cycle without selection, selected next cycle
    step(9'h010, 0, 0, 0, 1, 0, 8'h00, "R6 capture N");
    step(9'h020, 0, 1, 0, 0, 0, 8'h00, "R6 uses previous N");
    chk("R6 delayed N", upc, 9'h120);
    step(9'h030, 0, 1, 0, 0, 0, 8'h00, "R6 N now cleared");
    chk("R6 N cleared", upc, 9'h030);
    step(9'h000, 0, 0, 0, 0, 1, 8'h00, "R3 set Z");
    step(9'h044, 0, 1, 1, 1, 0, 8'h00, "R3 OR of conditions");
    chk("R3 Z path", upc, 9'h144);
    step(9'h000, 1, 0, 0, 0, 0, 8'h60, "R5 dispatch");
    chk("R5 dispatch 0x60", upc, 9'h060);
    step(9'h00F, 1, 0, 0, 0, 0, 8'hA0, "R5 dispatch merge");
    chk("R5 merged byte", upc, 9'h0AF);
    step(9'h100, 1, 0, 0, 0, 0, 8'h7E, "R7 dispatch high page");
    chk("R7 high page", upc, 9'h17E);

    // R8: input changes mid-cycle do not move upc
    hold = upc;
    succ = 9'h1FF; ub = 1; opc = 8'hFF; sn = 1; sz = 1;
    #2;
    chk("R8 stable between edges", upc, hold);

    for (int i = 0; i < 400; i++) begin
      logic [8:0] r = 9'($urandom);
      logic [7:0] o = 8'($urandom);
      int unsigned c = $urandom;
      step(r, c[0], c[1], c[2], c[3], c[4], o, "R3 random mix");
    end

    // R1: asynchronous reset mid-run
    step(9'h155, 0, 0, 0, 1, 1, 8'h00, "R2 before reset");
    #1 rst_ni = 1'b0;
    #1 chk("R1 async clear", upc, 9'h000);
    fn_m = 0; fz_m = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    step(9'h003, 0, 1, 1, 0, 0, 8'h00, "R1 flags cleared by reset");
    chk("R1 no stale flag", upc, 9'h003);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule